// File: doc/BRIEF.md
# Conversion Start and Busy Sequencer

This block times a single successive-approximation conversion against a master clock. The master clock enters as a level on `mclk` and is sampled by a faster system clock. Both of its edges are counted, so every timing decision has half-period resolution. A conversion is requested in one of two ways: a rising edge on `start_pin`, or a control-register write strobe (`ctl_wr`) that carries the software start bit (`ctl_go`).

When a request is accepted, the block puts the track/hold into hold and raises `busy`. It then waits for the next falling master-clock edge, and the conversion proper begins there. The conversion lasts 37 half-periods (18.5 master periods) if the request was seen while the master clock was low. In that case a full high phase lies ahead of the falling edge and the setup window is met. If the request was seen while the master clock was high, the conversion lasts 39 half-periods (19.5 periods).

When the count ends, `busy` falls, the track/hold returns to tracking and `done` pulses to mark that the result can be read. An acquisition window of two master periods then follows. Requests that arrive while `busy` is high or inside that window are ignored, and `start_dropped` records that one was lost.

Top module: `conv_start_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy`, `th_hold`, `done`, `sw_go_bit` and `start_dropped` are all 0.
- R2: A rising edge on `start_pin` that reaches an idle sequencer raises `busy` and `th_hold` on the second `clk` edge after the pin goes high; they are still low after the first.
- R3: A `ctl_wr` strobe with `ctl_go`=1 starts a conversion with the same latency as R2; a `ctl_wr` strobe with `ctl_go`=0 starts nothing.
- R4: The conversion begins at the first falling `mclk` edge after the request is sampled. `busy` falls on the 37th `mclk` edge (either polarity) after that falling edge if the request was sampled while `mclk` was low, and on the 39th edge if it was sampled while `mclk` was high. Each edge acts one `clk` later than its sampling, as in R2.
- R5: `th_hold` falls in the same cycle as `busy`, and `done` is high for exactly that one cycle.
- R6: After `busy` falls, a request is accepted only once four further `mclk` edges have acted; one cycle earlier it is ignored.
- R7: A request that arrives while `busy` is high is ignored and does not change when `busy` falls.
- R8: `start_dropped` goes to 1 on the cycle an ignored request acts, stays 1, and clears to 0 on the cycle a later request is accepted.
- R9: `sw_go_bit` reads 1 on the cycle after the software-start write and clears by itself on the next cycle, when the request is consumed.
- R10: Holding `start_pin` high starts only one conversion; a new start needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the master clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master-clock level, sampled on `clk` |
| start_pin | input | 1 | External conversion-start pin, rising-edge active |
| ctl_wr | input | 1 | One-cycle strobe at the end of a control-register write |
| ctl_go | input | 1 | Software start bit carried by that write |
| busy | output | 1 | High from acceptance to the end of the conversion |
| th_hold | output | 1 | Track/hold in hold (1) or track (0) |
| done | output | 1 | One-cycle pulse when the result becomes readable |
| sw_go_bit | output | 1 | Self-clearing software start bit |
| start_dropped | output | 1 | Sticky flag: a request was ignored since the last accepted start |

## Verification
Every input passes one sampling register, and the sequencer acts one `clk` later. So `busy` and `th_hold` rise two cycles after a request is driven, and `sw_go_bit` reads 1 one cycle after the write. The fall of `busy` is due 1 + H*N cycles after the falling `mclk` edge is sampled, where H is the half-period in `clk` cycles and N is 37 or 39. The bench derives N from the `mclk` phase it drove at the request. It generates `mclk` from its own cycle counter, so it knows in advance which cycle every edge reaches the block. It then compares the exact cycle in which `busy` falls, samples every output on the falling `clk` edge, and places the acquisition-boundary requests exactly one cycle before and at the first cycle allowed.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_CONV = 2'd2,
    ST_ACQ  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/convseq_edge.sv
module convseq_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] smp_q;
  logic [W-1:0] smp_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      smp_d <= '0;
    end else begin
      smp_q <= din;
      smp_d <= smp_q;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign lvl[b]  = smp_q[b];
    assign rise[b] = smp_q[b] & ~smp_d[b];
    assign fall[b] = ~smp_q[b] & smp_d[b];
  end
endmodule

// File: rtl/convseq_half_cnt.sv
module convseq_half_cnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/convseq_fsm.sv
module convseq_fsm
  import convseq_pkg::*;
#(
  parameter int HALF_MET  = 37,
  parameter int HALF_MISS = 39,
  parameter int ACQ_HALF  = 4,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          mclk_lvl,
  input  logic          mclk_fall,
  input  logic          mclk_edge,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          busy,
  output logic          hold,
  output logic          done,
  output logic          dropped
);
  localparam logic [CW-1:0] LAST_MET  = CW'(HALF_MET - 1);
  localparam logic [CW-1:0] LAST_MISS = CW'(HALF_MISS - 1);
  localparam logic [CW-1:0] LAST_ACQ  = CW'(ACQ_HALF - 1);

  seq_state_e state, state_n;
  logic       late, late_n;
  logic       accept;
  logic [CW-1:0] conv_last;

  assign accept    = (state == ST_IDLE) && req;
  assign conv_last = late ? LAST_MISS : LAST_MET;

  always_comb begin
    state_n = state;
    late_n  = late;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        state_n = ST_ARM;
        late_n  = mclk_lvl;
      end
      ST_ARM: if (mclk_fall) begin
        state_n = ST_CONV;
        cnt_clr = 1'b1;
      end
      ST_CONV: if (mclk_edge) begin
        if (cnt == conv_last) begin
          state_n = ST_ACQ;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_ACQ: if (mclk_edge) begin
        if (cnt == LAST_ACQ) state_n = ST_IDLE;
        else                 cnt_inc = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      late    <= 1'b0;
      busy    <= 1'b0;
      hold    <= 1'b0;
      done    <= 1'b0;
      dropped <= 1'b0;
    end else begin
      state <= state_n;
      late  <= late_n;
      busy  <= (state_n == ST_ARM) || (state_n == ST_CONV);
      hold  <= (state_n == ST_ARM) || (state_n == ST_CONV);
      done  <= (state == ST_CONV) && (state_n == ST_ACQ);
      if (accept)   dropped <= 1'b0;
      else if (req) dropped <= 1'b1;
    end
  end
endmodule

// File: rtl/conv_start_seq.sv
module conv_start_seq #(
  parameter int HALF_MET  = 37,
  parameter int HALF_MISS = 39,
  parameter int ACQ_HALF  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk,
  input  logic start_pin,
  input  logic ctl_wr,
  input  logic ctl_go,
  output logic busy,
  output logic th_hold,
  output logic done,
  output logic sw_go_bit,
  output logic start_dropped
);
  localparam int CNT_MAX = (HALF_MISS > ACQ_HALF) ? HALF_MISS : ACQ_HALF;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [1:0] ed_lvl, ed_rise, ed_fall;
  logic       req;
  logic       cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;

  // bit 0: master clock, bit 1: start pin
  convseq_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({start_pin, mclk}),
    .lvl  (ed_lvl),
    .rise (ed_rise),
    .fall (ed_fall)
  );

  always_ff @(posedge clk) begin
    if (rst)                  sw_go_bit <= 1'b0;
    else if (ctl_wr && ctl_go) sw_go_bit <= 1'b1;
    else                      sw_go_bit <= 1'b0;  // consumed on the cycle after the write
  end

  assign req = ed_rise[1] | sw_go_bit;

  convseq_half_cnt #(.CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt)
  );

  convseq_fsm #(
    .HALF_MET  (HALF_MET),
    .HALF_MISS (HALF_MISS),
    .ACQ_HALF  (ACQ_HALF),
    .CW        (CW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .mclk_lvl  (ed_lvl[0]),
    .mclk_fall (ed_fall[0]),
    .mclk_edge (ed_rise[0] | ed_fall[0]),
    .cnt       (cnt),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .busy      (busy),
    .hold      (th_hold),
    .done      (done),
    .dropped   (start_dropped)
  );
endmodule

// File: rtl/convseq_chk.sv
module convseq_chk #(
  parameter int HALF_MET  = 37,
  parameter int HALF_MISS = 39,
  parameter int ACQ_HALF  = 4
) (
  input logic clk,
  input logic rst,
  input logic mclk,
  input logic ctl_wr,
  input logic ctl_go,
  input logic busy,
  input logic th_hold,
  input logic done,
  input logic sw_go_bit,
  input logic start_dropped
);
  localparam int CNT_MAX = (HALF_MISS > ACQ_HALF) ? HALF_MISS : ACQ_HALF;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic mq, md, m_edge, m_fall;
  logic seen_fall;
  logic [CW-1:0] conv_cnt;
  logic [CW-1:0] acq_cnt;

  assign m_edge = mq ^ md;
  assign m_fall = ~mq & md;

  always_ff @(posedge clk) begin
    if (rst) begin
      mq <= 1'b0;
      md <= 1'b0;
      seen_fall <= 1'b0;
      conv_cnt  <= '0;
      acq_cnt   <= CW'(ACQ_HALF);
    end else begin
      mq <= mclk;
      md <= mq;
      if (!busy) begin
        seen_fall <= 1'b0;
        conv_cnt  <= '0;
        if (m_edge && acq_cnt != CW'(ACQ_HALF)) acq_cnt <= acq_cnt + 1'b1;
      end else begin
        acq_cnt <= '0;
        if (m_fall && !seen_fall)   seen_fall <= 1'b1;
        else if (seen_fall && m_edge) conv_cnt <= conv_cnt + 1'b1;
      end
    end
  end

  assert_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (conv_cnt == CW'(HALF_MET) || conv_cnt == CW'(HALF_MISS)));

  assert_track_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(th_hold));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $rose(th_hold));

  assert_done_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));

  assert_acq_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> acq_cnt == CW'(ACQ_HALF));

  assert_drop_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(start_dropped) |-> $rose(busy));

  assert_go_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (sw_go_bit && !(ctl_wr && ctl_go)) |=> !sw_go_bit);
endmodule

bind conv_start_seq convseq_chk #(
  .HALF_MET  (HALF_MET),
  .HALF_MISS (HALF_MISS),
  .ACQ_HALF  (ACQ_HALF)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mclk          (mclk),
  .ctl_wr        (ctl_wr),
  .ctl_go        (ctl_go),
  .busy          (busy),
  .th_hold       (th_hold),
  .done          (done),
  .sw_go_bit     (sw_go_bit),
  .start_dropped (start_dropped)
);

// File: tb/conv_start_seq_tb.sv
module conv_start_seq_tb;
  localparam int H  = 4;      // clk cycles per master half-period
  localparam int P2 = 2 * H;
  // [15] software start, [11:8] phase offset in clk cycles, [5:0] expected half-periods
  localparam logic [15:0] VEC [8] = '{
    16'h0125, 16'h0527, 16'h8225, 16'h8627,
    16'h0025, 16'h8427, 16'h0727, 16'h8325
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mclk = 1'b0;
  logic start_pin = 1'b0;
  logic ctl_wr = 1'b0;
  logic ctl_go = 1'b0;
  logic busy, th_hold, done, sw_go_bit, start_dropped;

  int cyc = 0;
  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) mclk <= 1'(((cyc + 1) / H) % 2);

  conv_start_seq u_dut (
    .clk (clk), .rst (rst), .mclk (mclk), .start_pin (start_pin),
    .ctl_wr (ctl_wr), .ctl_go (ctl_go), .busy (busy), .th_hold (th_hold),
    .done (done), .sw_go_bit (sw_go_bit), .start_dropped (start_dropped)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic run_conv(input bit sw, input int off, input int n, output int fall_p);
    int k, j, exp_fall, guard;
    @(negedge clk);
    while (((cyc + 1) % P2) != off) @(negedge clk);
    k = cyc + 1;
    j = (k / P2 + 1) * P2;
    exp_fall = j + 1 + H * n;
    if (sw) begin ctl_wr = 1'b1; ctl_go = 1'b1; end
    else start_pin = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_go = 1'b0;
    if (sw) chk(sw_go_bit == 1'b1, "R9 go bit set", int'(sw_go_bit), 1);
    chk(busy == 1'b0, sw ? "R3 latency" : "R2 latency", int'(busy), 0);
    @(negedge clk);
    chk(busy && th_hold, sw ? "R3 start" : "R2 start", int'({busy, th_hold}), 3);
    if (sw) chk(sw_go_bit == 1'b0, "R9 go bit clear", int'(sw_go_bit), 0);
    guard = 0;
    while (busy && guard < 500) begin
      if (!th_hold) chk(1'b0, "R5 hold during busy", 0, 1);
      @(negedge clk);
      guard++;
    end
    fall_p = cyc;
    chk(fall_p == exp_fall, "R4 busy fall cycle", fall_p, exp_fall);
    chk(done == 1'b1 && th_hold == 1'b0, "R5 done and track", int'({done, th_hold}), 2);
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", int'(done), 0);
    start_pin = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog R4 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int f;
    int k, j, exp_fall;
    repeat (4) @(negedge clk);
    chk({busy, th_hold, done, sw_go_bit, start_dropped} == 5'b0, "R1 in reset",
        int'({busy, th_hold, done, sw_go_bit, start_dropped}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, th_hold, done, sw_go_bit, start_dropped} == 5'b0, "R1 after reset",
        int'({busy, th_hold, done, sw_go_bit, start_dropped}), 0);

    // table of start kind, phase and expected length; R10: pin stays high through each run
    for (int i = 0; i < 8; i++) begin
      run_conv(VEC[i][15], int'(VEC[i][11:8]), int'(VEC[i][5:0]), f);
      repeat (6 * H) @(negedge clk);
      chk(busy == 1'b0, "R10 no retrigger", int'(busy), 0);
      chk(start_dropped == 1'b0, "R8 no drop", int'(start_dropped), 0);
    end

    // R3: write without the start bit
    ctl_wr = 1'b1; ctl_go = 1'b0;
    @(negedge clk);
    ctl_wr = 1'b0;
    repeat (3 * H) @(negedge clk);
    chk(busy == 1'b0 && sw_go_bit == 1'b0, "R3 write without go", int'({busy, sw_go_bit}), 0);

    // R6: request one cycle before the acquisition window closes is ignored
    run_conv(1'b0, 1, 37, f);
    wait_until(f + 4 * H - 2);
    start_pin = 1'b1;
    @(negedge clk);
    start_pin = 1'b0;
    wait_until(f + 4 * H + 3);
    chk(busy == 1'b0, "R6 early request ignored", int'(busy), 0);
    chk(start_dropped == 1'b1, "R8 drop set in acquisition", int'(start_dropped), 1);
    repeat (2 * H) @(negedge clk);
    run_conv(1'b0, 5, 39, f);
    chk(start_dropped == 1'b0, "R8 drop cleared by accept", int'(start_dropped), 0);

    // R6: request at the first allowed cycle is accepted
    wait_until(f + 4 * H - 1);
    ctl_wr = 1'b1; ctl_go = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_go = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R6 boundary request accepted", int'(busy), 1);
    for (int g = 0; g < 500 && busy; g++) @(negedge clk);
    repeat (6 * H) @(negedge clk);

    // R7/R8: request during busy is ignored and flagged
    @(negedge clk);
    while (((cyc + 1) % P2) != 2) @(negedge clk);
    k = cyc + 1;
    j = (k / P2 + 1) * P2;
    exp_fall = j + 1 + H * 37;
    ctl_wr = 1'b1; ctl_go = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_go = 1'b0;
    wait_until(k + 20);
    start_pin = 1'b1;
    @(negedge clk);
    start_pin = 1'b0;
    @(negedge clk);
    chk(start_dropped == 1'b1, "R8 drop set during busy", int'(start_dropped), 1);
    chk(busy == 1'b1, "R7 busy unaffected", int'(busy), 1);
    for (int g = 0; g < 500 && busy; g++) @(negedge clk);
    chk(cyc == exp_fall, "R7 busy fall unchanged", cyc, exp_fall);
    chk(start_dropped == 1'b1, "R8 drop sticky", int'(start_dropped), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule